// File: doc/BRIEF.md
# Operand Cache Maintenance Controller

This block keeps the per-line bookkeeping of a 4-way set-associative operand cache (valid bit, dirty bit and tag for each of 4 ways by 256 entries, 32-byte lines) and executes line maintenance on it. Software-style commands carry a 32-bit operand address and a privilege flag. When the top byte of that address selects the cache address array, the way and entry are taken directly from address bits, with no tag lookup. The block can then invalidate a line, purge it (write back if dirty, then drop it), or write it back and keep it.

A second request path takes a physical address, looks it up by tag in all four ways of the addressed set, and writes the line back only on a dirty hit. Every write-back leaves through a single valid/ready memory request carrying way, entry and tag. The block accepts no new work until the memory side takes that request. A test fill port preloads tag, valid and dirty state.

Top module: `ocache_maint`

## Requirements
- R1: After reset every line is invalid and clean, `cmd_ready` is 1, `wb_valid` is 0, and a write-back command to any line raises no memory request.
- R2: A command touches the array only when `cmd_addr[31:24]` is 0xF4. The way is `cmd_addr[14:13]` and the entry is `cmd_addr[12:5]`. Any other top byte gives `cmd_done` with no request and no state change.
- R3: Op code 2'b00 (invalidate) drops the selected line and never raises a request, even when the line is dirty.
- R4: Op code 2'b01 (purge) raises a request for a valid dirty line, then drops it. A clean or invalid line is dropped without a request.
- R5: Op code 2'b10 (write-back) raises a request for a valid dirty line and leaves it valid and clean. A clean or invalid line raises no request.
- R6: A command with `cmd_priv` = 0 pulses `cmd_err` (not `cmd_done`) one cycle after acceptance, raises no request, and changes no line.
- R7: A flush compares `flush_addr[31:13]` with the tag of each valid way at entry `flush_addr[12:5]`. A dirty hit raises a request naming the hit way and leaves the line valid and clean. A miss or a clean hit only pulses `flush_done`.
- R8: While `wb_valid` is 1 and `wb_ready` is 0, the way, entry and tag fields hold steady and `cmd_ready` is 0. The matching done pulse appears one cycle after the edge where `wb_ready` is seen.
- R9: Op code 2'b11 is a no-operation that still gives `cmd_done`. When a command and a flush are presented together, the command is taken first and the flush waits.
- R10: A command or flush that needs no write-back pulses its done output in the cycle right after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Maintenance command present |
| cmd_op | input | 2 | 00 invalidate, 01 purge, 10 write-back, 11 no-op |
| cmd_addr | input | 32 | Operand address of the command |
| cmd_priv | input | 1 | 1 when issued in privileged mode |
| cmd_ready | output | 1 | Block idle; a command or flush is taken this edge |
| cmd_done | output | 1 | One-cycle pulse: command finished |
| cmd_err | output | 1 | One-cycle pulse: address-error exception |
| flush_valid | input | 1 | Flush request present |
| flush_addr | input | 32 | Physical address to flush |
| flush_done | output | 1 | One-cycle pulse: flush finished |
| wb_valid | output | 1 | Write-back request to memory |
| wb_way | output | 2 | Way of the line written back |
| wb_index | output | 8 | Entry of the line written back |
| wb_tag | output | 19 | Tag of the line written back |
| wb_ready | input | 1 | Memory accepts the write-back |
| fill_en | input | 1 | Test fill strobe |
| fill_way | input | 2 | Way to fill |
| fill_index | input | 8 | Entry to fill |
| fill_tag | input | 19 | Tag to store |
| fill_valid | input | 1 | Valid bit to store |
| fill_dirty | input | 1 | Dirty bit to store |

## Verification
The bench sweeps all 1024 lines with a mix of valid and dirty state, op codes, privilege and top bytes. A design that wrote back on invalidate, dropped a line on write-back, or let a user-mode or out-of-area command touch the line shows it either in the immediate request or in a follow-up write-back probe of the same line. A flush sweep hits every way of every set on dirty, clean and missing lines. A wrong way encoding or a failure to clean the line after a flush shows up as a wrong `wb_way` or a second request. Randomised ready delays catch fields that drift or commands taken while a request is pending, and a simultaneous command-plus-flush catches a reversed priority.

// File: rtl/ocache_maint.sv
module ocache_maint #(
  parameter int ADDR_W = 32,
  parameter int IDX_W = 8,
  parameter int WAY_W = 2,
  parameter int OFF_W = 5,
  parameter logic [7:0] AREA_BYTE = 8'hF4,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_priv,
  output logic              cmd_ready,
  output logic              cmd_done,
  output logic              cmd_err,
  input  logic              flush_valid,
  input  logic [ADDR_W-1:0] flush_addr,
  output logic              flush_done,
  output logic              wb_valid,
  output logic [WAY_W-1:0]  wb_way,
  output logic [IDX_W-1:0]  wb_index,
  output logic [TAG_W-1:0]  wb_tag,
  input  logic              wb_ready,
  input  logic              fill_en,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [IDX_W-1:0]  fill_index,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_valid,
  input  logic              fill_dirty
);
  localparam int WAYS = 1 << WAY_W;
  localparam int SETS = 1 << IDX_W;
  localparam logic [1:0] OP_INV = 2'd0, OP_PURGE = 2'd1, OP_WB = 2'd2;

  logic [SETS-1:0]  vld [WAYS];
  logic [SETS-1:0]  drt [WAYS];
  logic [TAG_W-1:0] tags [WAYS][SETS];

  logic busy, pend_purge, pend_flush;

  wire [WAY_W-1:0] c_way  = cmd_addr[OFF_W+IDX_W +: WAY_W];
  wire [IDX_W-1:0] c_idx  = cmd_addr[OFF_W +: IDX_W];
  wire             c_area = cmd_addr[ADDR_W-1 -: 8] == AREA_BYTE;
  wire             c_dirty = vld[c_way][c_idx] & drt[c_way][c_idx];

  wire [IDX_W-1:0] f_idx = flush_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] f_tag = flush_addr[ADDR_W-1 : OFF_W+IDX_W];

  logic [WAYS-1:0] f_hit, f_drt;
  logic [WAY_W-1:0] f_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign f_hit[g] = vld[g][f_idx] && tags[g][f_idx] == f_tag;
    assign f_drt[g] = drt[g][f_idx];
  end

  always_comb begin
    f_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (f_hit[w]) f_way = WAY_W'(w);
  end

  wire take_c = !busy && cmd_valid;
  wire take_f = !busy && !cmd_valid && flush_valid;
  wire c_act  = take_c && cmd_priv && c_area;
  wire c_need = c_act && (cmd_op == OP_PURGE || cmd_op == OP_WB) && c_dirty;
  wire f_need = take_f && |(f_hit & f_drt);
  wire wb_fire = busy && wb_ready;

  assign cmd_ready = !busy;
  assign wb_valid  = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        vld[w] <= '0;
        drt[w] <= '0;
      end
    end else begin
      if (fill_en) begin
        vld[fill_way][fill_index] <= fill_valid;
        drt[fill_way][fill_index] <= fill_dirty;
      end
      if (c_act && cmd_op == OP_INV) begin
        vld[c_way][c_idx] <= 1'b0;
        drt[c_way][c_idx] <= 1'b0;
      end
      if (c_act && cmd_op == OP_PURGE && !c_dirty) begin
        vld[c_way][c_idx] <= 1'b0;
        drt[c_way][c_idx] <= 1'b0;
      end
      if (wb_fire) begin
        drt[wb_way][wb_index] <= 1'b0;
        if (pend_purge) vld[wb_way][wb_index] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tags[fill_way][fill_index] <= fill_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend_purge <= 1'b0;
      pend_flush <= 1'b0;
      wb_way     <= '0;
      wb_index   <= '0;
      wb_tag     <= '0;
      cmd_done   <= 1'b0;
      cmd_err    <= 1'b0;
      flush_done <= 1'b0;
    end else begin
      cmd_done   <= (take_c && cmd_priv && !c_need) || (wb_fire && !pend_flush);
      cmd_err    <= take_c && !cmd_priv;
      flush_done <= (take_f && !f_need) || (wb_fire && pend_flush);
      if (busy) begin
        if (wb_ready) busy <= 1'b0;
      end else if (c_need) begin
        busy       <= 1'b1;
        pend_purge <= cmd_op == OP_PURGE;
        pend_flush <= 1'b0;
        wb_way     <= c_way;
        wb_index   <= c_idx;
        wb_tag     <= tags[c_way][c_idx];
      end else if (f_need) begin
        busy       <= 1'b1;
        pend_purge <= 1'b0;
        pend_flush <= 1'b1;
        wb_way     <= f_way;
        wb_index   <= f_idx;
        wb_tag     <= tags[f_way][f_idx];
      end
    end
  end
endmodule

// File: rtl/ocache_maint_chk.sv
module ocache_maint_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W = 8,
  parameter int WAY_W = 2,
  parameter int TAG_W = 19,
  parameter logic [7:0] AREA_BYTE = 8'hF4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_priv,
  input logic              cmd_ready,
  input logic              cmd_done,
  input logic              cmd_err,
  input logic              flush_done,
  input logic              wb_valid,
  input logic [WAY_W-1:0]  wb_way,
  input logic [IDX_W-1:0]  wb_index,
  input logic [TAG_W-1:0]  wb_tag,
  input logic              wb_ready,
  input logic [(1<<WAY_W)-1:0] f_hit
);
  wire take_c  = cmd_valid && cmd_ready;
  wire in_area = cmd_addr[ADDR_W-1 -: 8] == AREA_BYTE;

  a_r8_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_way) && $stable(wb_index) && $stable(wb_tag));
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !cmd_ready);
  a_r8_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> !wb_valid && (cmd_done || flush_done));
  a_r6_user_error: assert property (@(posedge clk) disable iff (!rst_n)
    take_c && !cmd_priv |=> cmd_err && !cmd_done && !wb_valid);
  a_r2_outside_area: assert property (@(posedge clk) disable iff (!rst_n)
    take_c && cmd_priv && !in_area |=> cmd_done && !wb_valid);
  a_r3_invalidate_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    take_c && cmd_priv && in_area && cmd_op == 2'd0 |=> cmd_done && !wb_valid);
  a_r9_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
    take_c && cmd_priv && cmd_op == 2'd3 |=> cmd_done && !wb_valid);
  a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_hit));
  a_r10_done_err_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done && cmd_err));
endmodule

bind ocache_maint ocache_maint_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAY_W(WAY_W), .TAG_W(TAG_W), .AREA_BYTE(AREA_BYTE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .cmd_priv(cmd_priv), .cmd_ready(cmd_ready), .cmd_done(cmd_done), .cmd_err(cmd_err),
  .flush_done(flush_done), .wb_valid(wb_valid), .wb_way(wb_way), .wb_index(wb_index),
  .wb_tag(wb_tag), .wb_ready(wb_ready), .f_hit(f_hit)
);

// File: tb/sim_ocache_maint.sv
module sim_ocache_maint;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_priv = 0, flush_valid = 0, wb_ready = 0;
  logic [1:0] cmd_op = 0;
  logic [31:0] cmd_addr = 0, flush_addr = 0;
  logic cmd_ready, cmd_done, cmd_err, flush_done, wb_valid;
  logic [1:0] wb_way;
  logic [7:0] wb_index;
  logic [18:0] wb_tag;
  logic fill_en = 0, fill_valid = 0, fill_dirty = 0;
  logic [1:0] fill_way = 0;
  logic [7:0] fill_index = 0;
  logic [18:0] fill_tag = 0;

  int n_chk = 0, n_fail = 0;
  bit mv [4][256];
  bit md [4][256];

  always #(CLK_PERIOD/2) clk = ~clk;

  ocache_maint u0 (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [18:0] tg(input int w, input int i);
    return {w[1:0], i[7:0], 9'(w * 37 + i)};
  endfunction

  task automatic fill(input int w, input int i, input logic [18:0] t, input bit v, input bit d);
    @(negedge clk);
    fill_en = 1; fill_way = w[1:0]; fill_index = i[7:0]; fill_tag = t; fill_valid = v; fill_dirty = d;
    mv[w][i] = v; md[w][i] = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic issue(input bit fl, input logic [1:0] op, input logic [31:0] a, input bit pr,
                       input int dly, output bit gw, output logic [1:0] gway,
                       output logic [7:0] gidx, output logic [18:0] gtag,
                       output bit gdone, output bit gerr);
    @(negedge clk);
    if (fl) begin flush_valid = 1; flush_addr = a; end
    else begin cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_priv = pr; end
    @(negedge clk);
    cmd_valid = 0; flush_valid = 0;
    gw = wb_valid; gway = wb_way; gidx = wb_index; gtag = wb_tag; gerr = cmd_err;
    gdone = fl ? flush_done : cmd_done;
    if (gw) begin
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk(wb_valid && wb_way == gway && wb_index == gidx && wb_tag == gtag && !cmd_ready,
            "R8 hold", {wb_valid, cmd_ready, wb_tag}, {1'b1, 1'b0, gtag});
      end
      wb_ready = 1;
      @(negedge clk);
      wb_ready = 0;
      gdone = fl ? flush_done : cmd_done;
      gerr = gerr | cmd_err;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit gw, gd, ge;
    logic [1:0] gway;
    logic [7:0] gidx;
    logic [18:0] gtag;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !wb_valid && !cmd_done && !flush_done, "R1 reset outputs",
        {cmd_ready, wb_valid, cmd_done}, 3'b100);

    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 256; i++) begin
        issue(0, 2'd2, {8'hF4, 9'd0, w[1:0], i[7:0], 5'd0}, 1, 0, gw, gway, gidx, gtag, gd, ge);
        chk(!gw && gd, "R1 clean after reset", {gw, gd}, 2'b01);
      end

    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 256; i++) begin
        bit v, d, pr, act, ew, nv, nd;
        logic [1:0] op;
        logic [7:0] area;
        string rq;
        v = (i % 5) != 0;
        d = ((w + i) % 3) != 0;
        op = 2'((w * 7 + i) % 4);
        pr = (i % 11) != 0;
        area = (i % 13 == 0) ? 8'hF3 : (i % 17 == 0) ? 8'hF5 : 8'hF4;
        fill(w, i, tg(w, i), v, d);
        act = pr && area == 8'hF4;
        ew = act && (op == 2'd1 || op == 2'd2) && v && d;
        nv = v; nd = d;
        if (act && (op == 2'd0 || op == 2'd1)) nv = 0;
        if (act && (op == 2'd1 || op == 2'd2)) nd = 0;
        if (!pr) rq = "R6";
        else if (area != 8'hF4) rq = "R2";
        else if (op == 2'd0) rq = "R3";
        else if (op == 2'd1) rq = "R4";
        else if (op == 2'd2) rq = "R5";
        else rq = "R9";
        issue(0, op, {area, 9'(i * 3), w[1:0], i[7:0], 5'(i)}, pr, i % 3, gw, gway, gidx, gtag, gd, ge);
        chk({ge, gw, gd} == {!pr, ew, pr}, rq, {ge, gw, gd}, {!pr, ew, pr});
        if (!ew) chk(gd == pr, "R10 done timing", gd, pr);
        if (gw) chk(gway == w[1:0] && gidx == i[7:0] && gtag == tg(w, i), "R2 decode",
                    {gway, gidx, gtag}, {w[1:0], i[7:0], tg(w, i)});
        issue(0, 2'd2, {8'hF4, 9'd0, w[1:0], i[7:0], 5'd0}, 1, 0, gw, gway, gidx, gtag, gd, ge);
        chk(gw == (nv && nd), {rq, " state"}, gw, nv && nd);
      end

    for (int i = 0; i < 256; i++) begin
      for (int w = 0; w < 4; w++)
        fill(w, i, tg(w, i), ((i + w) % 4) != 0, ((i * 3 + w) % 5) != 0);
      for (int w = 0; w < 4; w++) begin
        bit ew;
        ew = mv[w][i] && md[w][i];
        issue(1, 2'd0, {tg(w, i), i[7:0], 5'd3}, 0, (i + w) % 4, gw, gway, gidx, gtag, gd, ge);
        chk(gw == ew && gd, "R7 flush", {gw, gd}, {ew, 1'b1});
        if (gw) chk(gway == w[1:0] && gidx == i[7:0] && gtag == tg(w, i), "R7 hit way",
                    {gway, gidx, gtag}, {w[1:0], i[7:0], tg(w, i)});
        issue(1, 2'd0, {tg(w, i), i[7:0], 5'd3}, 0, 0, gw, gway, gidx, gtag, gd, ge);
        chk(!gw && gd, "R7 reflush clean", {gw, gd}, 2'b01);
      end
      fill(0, i, tg(0, i), 1, 1);
      issue(1, 2'd0, {tg(0, i) ^ 19'h1, i[7:0], 5'd0}, 0, 0, gw, gway, gidx, gtag, gd, ge);
      chk(!gw && gd, "R7 miss", {gw, gd}, 2'b01);
    end

    fill(1, 10, tg(1, 10), 1, 1);
    fill(2, 20, tg(2, 20), 1, 1);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd2; cmd_priv = 1; cmd_addr = {8'hF4, 9'd0, 2'd1, 8'd10, 5'd0};
    flush_valid = 1; flush_addr = {tg(2, 20), 8'd20, 5'd0};
    @(negedge clk);
    cmd_valid = 0;
    chk(wb_valid && wb_way == 2'd1 && wb_index == 8'd10, "R9 command first",
        {wb_valid, wb_way, wb_index}, {1'b1, 2'd1, 8'd10});
    wb_ready = 1;
    @(negedge clk);
    wb_ready = 0;
    chk(cmd_done && !flush_done, "R8 done after ready", {cmd_done, flush_done}, 2'b10);
    @(negedge clk);
    flush_valid = 0;
    chk(wb_valid && wb_way == 2'd2 && wb_index == 8'd20, "R9 flush second",
        {wb_valid, wb_way, wb_index}, {1'b1, 2'd2, 8'd20});
    wb_ready = 1;
    @(negedge clk);
    wb_ready = 0;
    chk(flush_done && !cmd_done, "R8 flush done", {flush_done, cmd_done}, 2'b10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule